// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the processor-facing end of an interrupt controller. A distributor in front of it offers one candidate interrupt at a time: an ID, an 8-bit priority and a flag that says whether the source is edge-triggered. The block decides whether that candidate may reach the processor. It does this through an enable bit and a priority threshold, and it drives one interrupt request line.

Software uses four 32-bit registers on a simple read/write strobe bus. Reading the acknowledge register takes the current candidate. The ID becomes active, the distributor is told to drop the pending state of edge sources, and the request line falls. If nothing qualifies, the read returns the spurious code 1023 and leaves all state as it was. Writing an ID to the end-of-interrupt register retires an active ID, and the distributor is notified. An active ID is never offered again until it has been retired.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the enable bit and the priority threshold are zero, the request line is low, and a register read returns rdata and rvalid on the cycle after the read strobe.
- R2: Byte offset 0x0 is control; only bit 0, the signalling enable, is stored and read back. While it is 0 the request line stays low.
- R3: Offset 0x4 holds an 8-bit threshold in bits [7:0]. A candidate is signalled only when its priority is strictly less than the threshold, so a threshold of 0 blocks everything.
- R4: A read of offset 0x8 while a candidate qualifies returns its ID in bits [9:0] with zeros above. In the same cycle it pulses ack_valid with ack_id and ack_edge (a copy of the edge flag, used to clear pending) and marks the ID active.
- R5: A read of offset 0x8 while nothing qualifies returns 1023, gives no ack pulse and changes no state.
- R6: The request line falls in the cycle the acknowledge data appears. An active ID is not signalled or acknowledged again until it is retired.
- R7: Writing an active ID to bits [9:0] of offset 0xC clears its active state and pulses eoi_valid with eoi_id in the next cycle. The ID may be signalled again one cycle later.
- R8: An end-of-interrupt write naming an ID that is not active gives no eoi pulse and leaves every active state unchanged.
- R9: Candidate IDs at or above NUM_IDS, or at or above 1020, never qualify.
- R10: A request-line change caused by a candidate or by register state shows one clock edge after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_edge | input | 1 | Candidate is edge-triggered |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Pulse: an ID became active |
| ack_id | output | 10 | ID that became active |
| ack_edge | output | 1 | The acknowledged ID is edge-triggered (clear its pending) |
| eoi_valid | output | 1 | Pulse: an ID was retired |
| eoi_id | output | 10 | ID that was retired |

## Verification
The hardest case to reach is one where a candidate is still offered by the distributor while its ID is already active. In that case the block must give the spurious code and must not take end-of-interrupt writes for other IDs as a retirement. The bench reaches it by holding a level candidate steady across its own acknowledge. While the candidate is held, the bench reads the acknowledge register again and writes end-of-interrupt for a neighbouring ID that is not active. Only then does it retire the real ID and wait for the line to rise again. This is done for every ID, and the edge flag alternates from one ID to the next. A separate sweep covers the priority threshold against candidate priorities, including the values one below and equal to each threshold.

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface #(
  parameter int NUM_IDS = 64,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              cand_valid,
  input  logic [9:0]        cand_id,
  input  logic [7:0]        cand_prio,
  input  logic              cand_edge,
  output logic              cpu_irq,
  output logic              ack_valid,
  output logic [9:0]        ack_id,
  output logic              ack_edge,
  output logic              eoi_valid,
  output logic [9:0]        eoi_id
);
  localparam int LIM_INT = (NUM_IDS < 1020) ? NUM_IDS : 1020;
  localparam logic [9:0] ID_LIM = LIM_INT[9:0];
  localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_EOI  = ADDR_W'(12);
  localparam logic [9:0] SPURIOUS = 10'd1023;

  logic               ctrl_q;
  logic [7:0]         mask_q;
  logic [NUM_IDS-1:0] active_q, active_d;
  logic               irq_q;

  logic [IDX_W-1:0] cidx, eidx;
  logic             cand_ok, qualify, ack_hit, eoi_hit;
  logic [9:0]       eoi_req;

  assign cidx    = cand_id[IDX_W-1:0];
  assign eoi_req = bus_wdata[9:0];
  assign eidx    = eoi_req[IDX_W-1:0];
  assign cand_ok = cand_valid && (cand_id < ID_LIM);
  assign qualify = ctrl_q && cand_ok && (cand_prio < mask_q) && !active_q[cidx];
  assign ack_hit = bus_rd && (bus_addr == OFF_ACK) && qualify;
  assign eoi_hit = bus_wr && (bus_addr == OFF_EOI) && (eoi_req < ID_LIM) && active_q[eidx];

  always_comb begin
    active_d = active_q;
    if (ack_hit) active_d[cidx] = 1'b1;
    if (eoi_hit) active_d[eidx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= 1'b0;
      mask_q   <= 8'h00;
      active_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_CTRL) ctrl_q <= bus_wdata[0];
      if (bus_wr && bus_addr == OFF_MASK) mask_q <= bus_wdata[7:0];
      active_q <= active_d;
      irq_q    <= qualify && !ack_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      ack_valid  <= 1'b0;
      ack_id     <= '0;
      ack_edge   <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_id     <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          OFF_CTRL: bus_rdata <= {31'd0, ctrl_q};
          OFF_MASK: bus_rdata <= {24'd0, mask_q};
          OFF_ACK:  bus_rdata <= {22'd0, ack_hit ? cand_id : SPURIOUS};
          default:  bus_rdata <= '0;
        endcase
      end
      ack_valid <= ack_hit;
      if (ack_hit) begin
        ack_id   <= cand_id;
        ack_edge <= cand_edge;
      end
      eoi_valid <= eoi_hit;
      if (eoi_hit) eoi_id <= eoi_req;
    end
  end

  assign cpu_irq = irq_q;

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q |=> !cpu_irq);

  // R3
  below_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(cand_prio) < $past(mask_q));

  // R4
  ack_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> bus_rvalid && bus_rdata == {22'd0, ack_id} && ack_id < ID_LIM);

  // R6
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !cpu_irq && active_q[ack_id[IDX_W-1:0]]);

  // R7
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !active_q[eoi_id[IDX_W-1:0]]);

  // R5
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid && bus_rdata == 32'd1023 |-> !ack_valid);
endmodule

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
  localparam int NID = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic cand_valid = 1'b0;
  logic [9:0] cand_id = '0;
  logic [7:0] cand_prio = '0;
  logic cand_edge = 1'b0;
  logic cpu_irq, ack_valid, ack_edge, eoi_valid;
  logic [9:0] ack_id, eoi_id;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rd_val;
  logic rd_ok, rd_ack, rd_edge, wr_eoi;
  logic [9:0] rd_ackid, wr_eoiid;

  always #2.5 clk = ~clk;

  cpu_irq_iface #(.NUM_IDS(NID), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_edge(cand_edge), .cpu_irq(cpu_irq),
    .ack_valid(ack_valid), .ack_id(ack_id), .ack_edge(ack_edge),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    wr_eoi = eoi_valid; wr_eoiid = eoi_id;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    rd_val = bus_rdata; rd_ok = bus_rvalid;
    rd_ack = ack_valid; rd_ackid = ack_id; rd_edge = ack_edge;
    bus_rd = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk(cpu_irq == 1'b0, "R1 irq", cpu_irq, 0);
    rd(4'h0); chk(rd_ok && rd_val == 0, "R1 ctrl", rd_val, 0);
    rd(4'h4); chk(rd_ok && rd_val == 0, "R1 mask", rd_val, 0);

    // R2 readback of bit 0 only
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0);
    chk(rd_val == 1, "R2 ctrl readback", rd_val, 1);
    wr(4'h4, 32'h0000_01A5); rd(4'h4);
    chk(rd_val == 32'hA5, "R3 mask readback", rd_val, 32'hA5);

    // R3 / R10 threshold sweep
    cand_valid = 1'b1; cand_id = 10'd5; cand_edge = 1'b0;
    for (int m = 0; m < 256; m += 17) begin
      wr(4'h4, m);
      for (int p = 0; p < 256; p += 17) begin
        cand_prio = p[7:0]; step(1);
        chk(cpu_irq == (p < m), "R3 sweep", cpu_irq, p < m);
      end
      if (m > 0) begin
        cand_prio = 8'(m - 1); step(1);
        chk(cpu_irq == 1'b1, "R3 mask-1", cpu_irq, 1);
      end
      cand_prio = 8'(m); step(1);
      chk(cpu_irq == 1'b0, "R3 equal", cpu_irq, 0);
    end

    // R2 enable gating, R5 spurious when disabled
    wr(4'h4, 32'hF0); cand_prio = 8'h10; step(1);
    chk(cpu_irq == 1'b1, "R10 irq up", cpu_irq, 1);
    wr(4'h0, 32'h0); step(1);
    chk(cpu_irq == 1'b0, "R2 disabled", cpu_irq, 0);
    rd(4'h8);
    chk(rd_val == 1023 && !rd_ack, "R5 disabled ack", rd_val, 1023);
    wr(4'h0, 32'h1); step(1);
    chk(cpu_irq == 1'b1, "R5 no state change", cpu_irq, 1);

    // R4 R6 R7 R8 per-ID handshake
    for (int id = 0; id < NID; id++) begin
      cand_id = 10'(id); cand_edge = id[0]; cand_prio = 8'(id); step(1);
      chk(cpu_irq == 1'b1, "R10 candidate", cpu_irq, 1);
      rd(4'h8);
      chk(rd_val == id, "R4 ack id", rd_val, id);
      chk(rd_ack && rd_ackid == id && rd_edge == id[0], "R4 ack pulse", rd_ackid, id);
      chk(cpu_irq == 1'b0, "R6 irq drop", cpu_irq, 0);
      step(1);
      chk(cpu_irq == 1'b0, "R6 held off", cpu_irq, 0);
      rd(4'h8);
      chk(rd_val == 1023 && !rd_ack, "R6 re-ack spurious", rd_val, 1023);
      wr(4'hC, (id ^ 1));
      chk(!wr_eoi, "R8 stray eoi", wr_eoi, 0);
      step(1);
      chk(cpu_irq == 1'b0, "R8 still active", cpu_irq, 0);
      wr(4'hC, id);
      chk(wr_eoi && wr_eoiid == id, "R7 eoi pulse", wr_eoiid, id);
      step(1);
      chk(cpu_irq == 1'b1, "R7 re-signal", cpu_irq, 1);
    end

    // R9 out-of-range IDs
    cand_prio = 8'h00;
    cand_id = 10'(NID); step(1);
    chk(cpu_irq == 1'b0, "R9 id=NUM_IDS", cpu_irq, 0);
    cand_id = 10'd1020; step(1);
    chk(cpu_irq == 1'b0, "R9 id=1020", cpu_irq, 0);
    cand_id = 10'd1023; step(1);
    rd(4'h8);
    chk(rd_val == 1023 && !rd_ack, "R9 ack 1023", rd_val, 1023);
    // R5 no candidate
    cand_valid = 1'b0; cand_id = 10'd3; step(1);
    rd(4'h8);
    chk(rd_val == 1023 && !rd_ack, "R5 empty", rd_val, 1023);
    cand_valid = 1'b1; step(1);
    chk(cpu_irq == 1'b1, "R5 state kept", cpu_irq, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule